// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block collects service requests from four peripherals and decides which one gets the next bus transfer cycle. Request lines come in without any timing relation to the block clock, so each one passes through a two-stage synchronizer first. Once a synchronized request from an enabled channel is present, the block asks the processor for the system bus with a hold request. It then waits for the hold acknowledge. After that it grants one channel for exactly one transfer cycle by pulling that channel's active-low acknowledge low. The winner is chosen either by a fixed ranking or by a rotating scheme in which the most recently served channel drops to the bottom. The scheme can be switched at run time through a mode register.

Each channel has a 16-bit transfer register. Its top two bits give the kind of operation and its lower fourteen bits give the remaining cycle count. Every completed cycle counts the serviced channel down. When a channel's count passes zero, the block sets that channel's completion flag and emits a one-cycle pulse. Software reads the flags through a status port, and the read clears them. A ready input stretches the current transfer cycle for as long as it stays low.

Top module: `dma_req_arbiter`

## Requirements
- R1: There are four request inputs and four active-low acknowledge outputs. At most one acknowledge is low at a time, and only while a transfer cycle is in progress. After reset all acknowledges are high and the hold request is low.
- R2: A synchronized request from an enabled channel raises `hold_req_o`. No acknowledge goes low until `hold_ack_i` has been seen at 1.
- R3: With the rotate bit at 0, the lowest-numbered enabled requesting channel wins, so channel 0 ranks first and channel 3 last.
- R4: With the rotate bit at 1, the search starts at the channel after the one served last. After reset the channel served last is taken to be channel 3, so channel 0 ranks first.
- R5: A write to address 4 loads the mode register: bits [3:0] are the per-channel enables and bit 4 is the rotate bit. A request from a disabled channel raises no hold request and gets no acknowledge.
- R6: A write to address c (0 to 3) loads channel c's register. Bits [15:14] hold the operation (00 verify, 01 write, 10 read, 11 treated as verify) and bits [13:0] hold the count. `op_type_o` shows the granted channel's operation during the transfer cycle, with 11 reported as 00. Each completed cycle decrements the count by one.
- R7: A cycle that completes while the channel's count is 0 wraps the count to 16383 and sets that channel's status flag. It also drives `tc_o` high for exactly the one clock cycle that follows the completing edge.
- R8: `stat_o` bit c is channel c's completion flag. A rising edge with `stat_rd_i` high clears all flags, but a flag set on that same edge stays set. Reset clears all flags.
- R9: While `ready_i` is low during a transfer cycle, the acknowledge, the grant and the counts stay frozen. The cycle completes on the first edge at which `ready_i` is high.
- R10: When no enabled request remains after a cycle, `hold_req_o` falls. No new hold request is raised while `hold_ack_i` is still 1.
- R11: Requests pass through two synchronizing flops. `hold_req_o` rises after the third rising edge that follows a request appearing at an idle, enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_i | input | 4 | Asynchronous peripheral requests, one per channel |
| hold_ack_i | input | 1 | Bus granted by the processor |
| ready_i | input | 1 | Low inserts wait states into the transfer cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0-3 channel registers, 4 mode register |
| wr_data_i | input | 16 | Write data |
| stat_rd_i | input | 1 | Status read strobe, clears the flags |
| hold_req_o | output | 1 | Bus request to the processor |
| dack_n_o | output | 4 | Active-low per-channel acknowledge |
| stat_o | output | 4 | Terminal-count flags |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| op_type_o | output | 2 | Operation of the cycle in progress |

## Verification
A request shows up on `hold_req_o` three edges after it is applied. An acknowledge appears on the edge after hold acknowledge is seen, and it lasts until the first edge with ready high. The terminal-count pulse and the status flag are due one edge after that completing edge. The bench queues the expected channel, operation and pulse for each grant. The monitor samples on falling edges and pops an item only when it sees an acknowledge with ready high. It then checks `tc_o` at exactly the next falling edge. Synchronizer latency is checked cycle by cycle, and the frozen state during waits is checked by comparing each stalled sample with the one before it.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
    localparam int CH_NUM    = 4;
    localparam int REG_W     = 16;
    localparam int OP_W      = 2;
    localparam int CNT_W     = REG_W - OP_W;
    localparam int ADDR_W    = 3;
    localparam int MODE_ADDR = CH_NUM;

    typedef enum logic [OP_W-1:0] {
        OP_VERIFY = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_BAD    = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HREQ,
        ST_XFER,
        ST_RELS
    } st_e;

    typedef struct packed {
        op_e              op;
        logic [CNT_W-1:0] cnt;
    } xreg_t;

    function automatic op_e op_map(op_e o);
        return (o == OP_BAD) ? OP_VERIFY : o;
    endfunction
endpackage

// File: rtl/dmaarb_sync.sv
module dmaarb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    input  logic           rot,
    input  logic [CHW-1:0] last,
    output logic           any,
    output logic [CHW-1:0] win
);
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        any   = |req;
        for (int k = 0; k < NCH; k++) begin
            int idx;
            idx = rot ? ((int'(last) + 1 + k) % NCH) : k;
            if (!found && req[idx]) begin
                win   = CHW'(idx);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmaarb_count.sv
module dmaarb_count
    import dmaarb_pkg::*;
#(
    parameter int NCH  = CH_NUM,
    parameter int CHW  = $clog2(NCH),
    parameter int ADRW = ADDR_W,
    parameter int DW   = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en_i,
    input  logic [ADRW-1:0] wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            done_i,
    input  logic [CHW-1:0]  grant_i,
    input  logic            stat_rd_i,
    output op_e             op_o,
    output logic [NCH-1:0]  stat_o,
    output logic            tc_o
);
    xreg_t          regs [NCH];
    logic [NCH-1:0] hit;
    logic [NCH-1:0] flags;

    always_comb begin
        for (int c = 0; c < NCH; c++)
            hit[c] = done_i && (grant_i == CHW'(c)) && (regs[c].cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) regs[c] <= '0;
            flags <= '0;
            tc_o  <= 1'b0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_en_i && wr_addr_i == ADRW'(c))
                    regs[c] <= xreg_t'(wr_data_i);
                else if (done_i && grant_i == CHW'(c))
                    regs[c].cnt <= regs[c].cnt - 1'b1;
            end
            flags <= (stat_rd_i ? '0 : flags) | hit;
            tc_o  <= |hit;
        end
    end

    assign op_o   = op_map(regs[grant_i].op);
    assign stat_o = flags;

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tc_o |=> !tc_o); // R7
    AST_FLAG_WITH_TC: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> (stat_o != '0)); // R8
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dmaarb_pkg::*;
#(
    parameter int NCH         = CH_NUM,
    parameter int SYNC_STAGES = 2,
    parameter int ADRW        = ADDR_W,
    parameter int DW          = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  dreq_i,
    input  logic            hold_ack_i,
    input  logic            ready_i,
    input  logic            wr_en_i,
    input  logic [ADRW-1:0] wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            stat_rd_i,
    output logic            hold_req_o,
    output logic [NCH-1:0]  dack_n_o,
    output logic [NCH-1:0]  stat_o,
    output logic            tc_o,
    output logic [1:0]      op_type_o
);
    localparam int CHW     = $clog2(NCH);
    localparam int ROT_BIT = NCH;

    st_e            state;
    logic [CHW-1:0] grant;
    logic [CHW-1:0] last;
    logic [NCH-1:0] en_q;
    logic           rot_q;
    logic [NCH-1:0] req_s;
    logic [NCH-1:0] live;
    logic           any;
    logic [CHW-1:0] win;
    logic           done;
    op_e            grant_op;

    dmaarb_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(dreq_i), .q(req_s)
    );

    assign live = req_s & en_q;

    dmaarb_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req(live), .rot(rot_q), .last(last), .any(any), .win(win)
    );

    assign done = (state == ST_XFER) && ready_i;

    dmaarb_count #(.NCH(NCH), .CHW(CHW), .ADRW(ADRW), .DW(DW)) u_count (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .done_i(done), .grant_i(grant), .stat_rd_i(stat_rd_i),
        .op_o(grant_op), .stat_o(stat_o), .tc_o(tc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            rot_q <= 1'b0;
        end else if (wr_en_i && wr_addr_i == ADRW'(MODE_ADDR)) begin
            en_q  <= wr_data_i[NCH-1:0];
            rot_q <= wr_data_i[ROT_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            grant <= '0;
            last  <= CHW'(NCH - 1);
        end else begin
            case (state)
                ST_IDLE: if (any && !hold_ack_i) state <= ST_HREQ;
                ST_HREQ: begin
                    if (!any) state <= ST_RELS;
                    else if (hold_ack_i) begin
                        grant <= win;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: if (ready_i) begin
                    last  <= grant;
                    state <= ST_HREQ;
                end
                ST_RELS: if (!hold_ack_i) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign hold_req_o = (state == ST_HREQ) || (state == ST_XFER);

    always_comb begin
        dack_n_o = '1;
        if (state == ST_XFER) dack_n_o[grant] = 1'b0;
    end

    assign op_type_o = (state == ST_XFER) ? grant_op : OP_VERIFY;

    AST_NO_ACK_BEFORE_HLDA: assert property (@(posedge clk) disable iff (rst)
        (hold_req_o && !hold_ack_i && dack_n_o == '1) |=> (dack_n_o == '1)); // R2
    AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (dack_n_o != '1 && !ready_i) |=> $stable(dack_n_o)); // R9
    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HREQ && hold_ack_i && any) |=> ((~dack_n_o & $past(live)) != '0)); // R5
    AST_NO_REHOLD: assert property (@(posedge clk) disable iff (rst)
        (!hold_req_o && hold_ack_i) |=> !hold_req_o); // R10
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        $countones(~dack_n_o) <= 1); // R1
endmodule

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  dreq = '0;
    logic        hold_ack = 1'b0;
    logic        ready = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        stat_rd = 1'b0;
    logic        hold_req;
    logic [3:0]  dack_n;
    logic [3:0]  stat;
    logic        tc;
    logic [1:0]  op_type;

    dma_req_arbiter u0 (
        .clk(clk), .rst(rst), .dreq_i(dreq), .hold_ack_i(hold_ack),
        .ready_i(ready), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .stat_rd_i(stat_rd), .hold_req_o(hold_req),
        .dack_n_o(dack_n), .stat_o(stat), .tc_o(tc), .op_type_o(op_type)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        int    ch;
        int    op;
        bit    tc;
        string tag;
    } exp_t;
    exp_t q[$];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int cnt_m[4] = '{0, 0, 0, 0};
    int op_m[4]  = '{0, 0, 0, 0};
    int last_m   = 3;
    bit [3:0] flags_m = '0;

    bit ack_en = 0;
    bit force_ack = 0;
    bit stall = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Processor model: hold acknowledge follows hold request one edge later.
    initial forever begin
        @(posedge clk); #1;
        hold_ack = force_ack ? 1'b1 : (ack_en & hold_req);
        ready    = stall ? (cyc % 3 == 2) : 1'b1;
        cyc++;
    end

    // Monitor: pops one expected item for each completing transfer cycle.
    bit       pend_tc = 0;
    bit       pend_exp = 0;
    bit       stalled_prev = 0;
    bit [3:0] prev_dack = '1;
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (pend_tc) begin
                chk(tc == pend_exp, "R7 tc pulse", tc, pend_exp);
                pend_tc = 0;
            end else if (tc) begin
                chk(1'b0, "R7 stray tc", tc, 0);
            end
            if (stalled_prev)
                chk(dack_n == prev_dack, "R9 frozen ack", dack_n, prev_dack);
            if (dack_n != 4'hF && ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 unexpected grant", dack_n, 4'hF);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk(dack_n == ~(4'b1 << it.ch), it.tag, dack_n, ~(4'b1 << it.ch) & 4'hF);
                    chk(op_type == it.op, "R6 op type", op_type, it.op);
                    pend_tc = 1;
                    pend_exp = it.tc;
                end
            end
            stalled_prev = (dack_n != 4'hF) && !ready;
            prev_dack = dack_n;
        end
    end

    function automatic int ref_pick(bit [3:0] r, bit rot, int last);
        for (int k = 0; k < 4; k++) begin
            int c;
            c = rot ? (last + 1 + k) % 4 : k;
            if (r[c]) return c;
        end
        return -1;
    endfunction

    task automatic push_seq(input bit [3:0] r, input bit rot, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            int c;
            c = ref_pick(r, rot, last_m);
            it.ch = c;
            it.op = op_m[c];
            it.tc = (cnt_m[c] == 0);
            it.tag = tag;
            if (it.tc) flags_m[c] = 1'b1;
            cnt_m[c] = (cnt_m[c] + 16383) % 16384;
            last_m = c;
            q.push_back(it);
        end
    endtask

    // Called just after an edge or just after a falling edge; holds one rising edge.
    task automatic wr(input int addr, input int data);
        wr_en = 1'b1;
        wr_addr = addr[2:0];
        wr_data = data[15:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic load_ch(input int ch, input int op, input int count);
        wr(ch, (op << 14) | count);
        cnt_m[ch] = count;
        op_m[ch] = (op == 3) ? 0 : op;
    endtask

    task automatic drain_then_disable(input bit rot);
        do begin
            @(negedge clk); #1;
        end while (q.size() != 0);
        wr(4, rot << 4);
        stall = 0;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic run_phase(input bit [3:0] r, input bit [3:0] en, input bit rot,
                             input int n, input bit st, input string tag);
        dreq = r;
        repeat (4) @(posedge clk);
        #1;
        push_seq(r & en, rot, n, tag);
        stall = st;
        wr(4, (rot << 4) | en);
        drain_then_disable(rot);
        chk(hold_req == 1'b0, "R10 hold dropped", hold_req, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        chk(1'b0, "watchdog", 0, 1);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(hold_req == 1'b0, "R1 reset hold", hold_req, 0);
        chk(dack_n == 4'hF, "R1 reset ack", dack_n, 4'hF);
        chk(stat == 4'h0, "R8 reset flags", stat, 0);
        chk(tc == 1'b0, "R7 reset pulse", tc, 0);
        @(posedge clk); #1;

        load_ch(0, 1, 5);
        load_ch(1, 2, 2);
        load_ch(2, 3, 1);
        load_ch(3, 0, 0);

        // R11 latency and R2 wait for hold acknowledge
        wr(4, 4'b0001);
        dreq = 4'b0001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(hold_req == 1'b0, "R11 two edges", hold_req, 0);
        @(posedge clk); @(negedge clk);
        chk(hold_req == 1'b1, "R11 third edge", hold_req, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(hold_req == 1'b1, "R2 hold held", hold_req, 1);
        chk(dack_n == 4'hF, "R2 no ack without grant", dack_n, 4'hF);
        #1;
        push_seq(4'b0001, 0, 1, "R2 first grant");
        ack_en = 1;
        drain_then_disable(0);
        chk(hold_req == 1'b0, "R10 hold dropped", hold_req, 0);

        // R5 disabled channel requesting
        dreq = 4'b0100;
        wr(4, 4'b0001);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(hold_req == 1'b0, "R5 disabled no hold", hold_req, 0);
        chk(dack_n == 4'hF, "R5 disabled no ack", dack_n, 4'hF);
        @(posedge clk); #1;

        // R10 no new hold while acknowledge still high
        force_ack = 1;
        wr(4, 4'b0100);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(hold_req == 1'b0, "R10 no hold while ack", hold_req, 0);
        #1;
        push_seq(4'b0100, 0, 1, "R6 illegal op grant");
        force_ack = 0;
        drain_then_disable(0);

        // R3 fixed priority
        run_phase(4'b1111, 4'b1111, 0, 3, 0, "R3 fixed all");
        // R3 fixed with waits, ch1 reaches terminal count (R7, R9)
        run_phase(4'b1010, 4'b1111, 0, 3, 1, "R3 fixed pair");
        // R4 rotating priority
        run_phase(4'b1111, 4'b1111, 1, 6, 0, "R4 rotate all");
        run_phase(4'b1011, 4'b1101, 1, 4, 1, "R4 rotate subset");

        // R8 status read clears
        @(negedge clk);
        chk(stat == flags_m, "R8 flags", stat, flags_m);
        #1;
        stat_rd = 1'b1;
        @(posedge clk); #1;
        stat_rd = 1'b0;
        flags_m = '0;
        @(negedge clk);
        chk(stat == 4'h0, "R8 cleared", stat, 0);

        dreq = '0;
        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R1 queue empty", q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule